// File: doc/BRIEF.md
# Byte-Word Lane-Interleaved FIFO

This block sits between a byte-wide character stream and a 16-bit word stream, buffering in both directions. Each direction stores its bytes in a pair of first-word-fall-through byte lanes. Consecutive bytes go to alternate lanes, so a whole word can enter or leave in one beat while the character side still moves one byte per handshake.

In the transmit direction, characters enter one per beat and leave as words. The older byte is in the low half. When only one byte is left, the final beat carries that lone byte in the low half and has both its last and single-character flags set. A flush request tells the packetizing logic that enough data has gathered, or that data has waited too long. The request carries the pending entry count and a flag that is set when no lone trailing byte exists. In the receive direction, words enter and characters leave one per beat. A flagged final beat may carry just one byte. An alignment bit then swaps the lanes that take the low and high halves, which keeps the character order intact across odd-length packets. Each of the four lanes reports its occupancy.

Top module: `bwl_fifo`

## Requirements
- R1: After synchronous reset all lane counts are 0, tx_word_valid, rx_char_valid and flush_valid are 0, and tx_char_ready and rx_word_ready are 1.
- R2: Accepted transmit characters alternate between the two transmit lanes. The first one after reset goes to lane 0. tx_char_ready is 1 exactly when the lane due next is not full, so it is 0 once 2*DEPTH bytes are stored.
- R3: A transmit word beat, while both transmit lanes hold data, carries the older byte in bits 7:0 and the next byte in bits 15:8. It has single=0, and last=1 only when these two bytes are all that is stored.
- R4: When exactly one transmit byte is stored, the word beat has bits 7:0 = that byte, bits 15:8 = 0, last=1 and single=1. The byte pairing of later beats stays in arrival order.
- R5: With fewer than LEVEL_LIMIT+1 bytes stored, flush_valid rises on the 23rd clock edge after the edge that accepted a byte into empty transmit lanes (default WAIT_LIMIT=20).
- R6: When the transmit lanes together hold more than LEVEL_LIMIT (8) bytes, flush_valid rises. flush_count then holds the sum of both lane counts, and flush_even is 1 exactly when both lane counts were equal.
- R7: flush_valid and flush_count hold until flush_ack. flush_ack while flush_valid=1 clears flush_valid on the next edge and restarts the wait timer.
- R8: A receive word beat without both flags is accepted only when neither receive lane is full. Its bits 7:0 come out as a character before its bits 15:8.
- R9: A receive beat with last=1 and single=1 stores only bits 7:0; bits 15:8 never appear on rx_char_data. Later words continue in arrival order.
- R10: rx_char_valid is 1 exactly when the receive lane due next holds data. rx_char_ready while rx_char_valid=0 changes no count and loses no data.
- R11: The four count outputs give the number of bytes held in each lane, and each changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_char_valid | input | 1 | Transmit character offered |
| tx_char_ready | output | 1 | Transmit character can be taken |
| tx_char_data | input | 8 | Transmit character |
| tx_word_valid | output | 1 | Transmit word beat available |
| tx_word_ready | input | 1 | Consumer takes the transmit word beat |
| tx_word_data | output | 16 | Transmit word, older byte low |
| tx_word_last | output | 1 | Beat empties the transmit lanes |
| tx_word_single | output | 1 | Beat carries one byte only |
| flush_valid | output | 1 | Flush request pending |
| flush_count | output | CW+1 | Sum of transmit lane counts at request time |
| flush_even | output | 1 | Transmit lane counts were equal |
| flush_ack | input | 1 | Flush request consumed |
| rx_word_valid | input | 1 | Receive word beat offered |
| rx_word_ready | output | 1 | Receive word beat can be taken |
| rx_word_data | input | 16 | Receive word |
| rx_word_last | input | 1 | Final beat of a packet |
| rx_word_single | input | 1 | Final beat holds only its low byte |
| rx_char_valid | output | 1 | Receive character available |
| rx_char_ready | input | 1 | Consumer takes the receive character |
| rx_char_data | output | 8 | Receive character |
| tx_lane0_count | output | CW | Bytes in transmit lane 0 |
| tx_lane1_count | output | CW | Bytes in transmit lane 1 |
| rx_lane0_count | output | CW | Bytes in receive lane 0 |
| rx_lane1_count | output | CW | Bytes in receive lane 1 |

## Verification
The assertions assume that flush_ack is raised only while flush_valid is 1, and that reset is held for at least one edge before traffic starts. They make no assumption about how long valid is held or how the flag bits are combined. The stimulus raises flush_ack only after it has seen a pending request, and only one cycle at a time. It applies every other input freely, including ready with nothing to read and valid against full lanes.

// File: rtl/bwl_pkg.sv
package bwl_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
        logic              single;
    } beat_t;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_WAIT,
        FL_REQ
    } flush_st_e;

    function automatic logic lone_beat(beat_t b);
        return b.last && b.single;
    endfunction

endpackage

// File: rtl/bwl_lane.sv
module bwl_lane
    import bwl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  byte_t                      din,
    input  logic                       pop,
    output byte_t                      dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  cnt;
    logic           do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/bwl_tx_path.sv
module bwl_tx_path
    import bwl_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int WAIT_LIMIT  = 20,
    parameter int LEVEL_LIMIT = 8,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ch_valid,
    output logic          ch_ready,
    input  byte_t         ch_data,
    output logic          wd_valid,
    input  logic          wd_ready,
    output beat_t         wd_beat,
    output logic          fl_valid,
    output logic [CW:0]   fl_count,
    output logic          fl_even,
    input  logic          fl_ack,
    output logic [CW-1:0] cnt0,
    output logic [CW-1:0] cnt1
);
    localparam int WCW = $clog2(WAIT_LIMIT + 2);

    logic [1:0]    push, pop, full, empty;
    byte_t         dout [2];
    logic [CW-1:0] cnt  [2];
    logic          wr_sel, rd_sel, pair_ok, take;
    logic [CW:0]   total;
    flush_st_e     fl_st;
    logic [WCW-1:0] wait_cnt;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bwl_lane #(.DEPTH(DEPTH)) lane_i (
            .clk(clk), .rst(rst),
            .push(push[g]), .din(ch_data),
            .pop(pop[g]), .dout(dout[g]),
            .full(full[g]), .empty(empty[g]), .count(cnt[g])
        );
    end

    assign cnt0     = cnt[0];
    assign cnt1     = cnt[1];
    assign total    = {1'b0, cnt[0]} + {1'b0, cnt[1]};
    assign ch_ready = !full[wr_sel];
    assign pair_ok  = !empty[0] && !empty[1];
    assign wd_valid = !empty[rd_sel];
    assign take     = wd_valid && wd_ready;
    assign fl_valid = (fl_st == FL_REQ);

    always_comb begin
        wd_beat.data   = pair_ok ? {dout[!rd_sel], dout[rd_sel]} : {8'h00, dout[rd_sel]};
        wd_beat.last   = pair_ok ? (total == (CW+1)'(2)) : 1'b1;
        wd_beat.single = !pair_ok;
        for (int i = 0; i < 2; i++) begin
            push[i] = ch_valid && ch_ready && (wr_sel == 1'(i));
            pop[i]  = take && (pair_ok || (rd_sel == 1'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sel   <= 1'b0;
            rd_sel   <= 1'b0;
            fl_st    <= FL_IDLE;
            wait_cnt <= '0;
            fl_count <= '0;
            fl_even  <= 1'b0;
        end else begin
            if (ch_valid && ch_ready) wr_sel <= !wr_sel;
            if (take && !pair_ok)     rd_sel <= !rd_sel;
            case (fl_st)
                FL_IDLE: begin
                    wait_cnt <= '0;
                    if (total != '0) fl_st <= FL_WAIT;
                end
                FL_WAIT: begin
                    if (total == '0) begin
                        fl_st <= FL_IDLE;
                    end else if (wait_cnt > WCW'(WAIT_LIMIT) ||
                                 total > (CW+1)'(LEVEL_LIMIT)) begin
                        fl_st    <= FL_REQ;
                        fl_count <= total;
                        fl_even  <= (cnt[0] == cnt[1]);
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                FL_REQ: begin
                    if (fl_ack) begin
                        fl_st    <= FL_IDLE;
                        wait_cnt <= '0;
                    end
                end
                default: fl_st <= FL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bwl_rx_path.sv
module bwl_rx_path
    import bwl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wd_valid,
    output logic          wd_ready,
    input  beat_t         wd_beat,
    output logic          ch_valid,
    input  logic          ch_ready,
    output byte_t         ch_data,
    output logic [CW-1:0] cnt0,
    output logic [CW-1:0] cnt1
);
    logic [1:0]    push, pop, full, empty;
    byte_t         din  [2];
    byte_t         dout [2];
    logic [CW-1:0] cnt  [2];
    logic          align, rd_sel, lone, acc;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bwl_lane #(.DEPTH(DEPTH)) lane_i (
            .clk(clk), .rst(rst),
            .push(push[g]), .din(din[g]),
            .pop(pop[g]), .dout(dout[g]),
            .full(full[g]), .empty(empty[g]), .count(cnt[g])
        );
    end

    assign cnt0     = cnt[0];
    assign cnt1     = cnt[1];
    assign lone     = lone_beat(wd_beat);
    assign wd_ready = lone ? !full[align] : (!full[0] && !full[1]);
    assign acc      = wd_valid && wd_ready;
    assign ch_valid = !empty[rd_sel];
    assign ch_data  = dout[rd_sel];

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            push[i] = acc && ((align == 1'(i)) || !lone);
            din[i]  = (align == 1'(i)) ? wd_beat.data[7:0] : wd_beat.data[15:8];
            pop[i]  = ch_valid && ch_ready && (rd_sel == 1'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            align  <= 1'b0;
            rd_sel <= 1'b0;
        end else begin
            if (acc && lone)           align  <= !align;
            if (ch_valid && ch_ready)  rd_sel <= !rd_sel;
        end
    end

endmodule

// File: rtl/bwl_fifo.sv
module bwl_fifo
    import bwl_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int WAIT_LIMIT  = 20,
    parameter int LEVEL_LIMIT = 8,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_char_valid,
    output logic          tx_char_ready,
    input  logic [7:0]    tx_char_data,
    output logic          tx_word_valid,
    input  logic          tx_word_ready,
    output logic [15:0]   tx_word_data,
    output logic          tx_word_last,
    output logic          tx_word_single,
    output logic          flush_valid,
    output logic [CW:0]   flush_count,
    output logic          flush_even,
    input  logic          flush_ack,
    input  logic          rx_word_valid,
    output logic          rx_word_ready,
    input  logic [15:0]   rx_word_data,
    input  logic          rx_word_last,
    input  logic          rx_word_single,
    output logic          rx_char_valid,
    input  logic          rx_char_ready,
    output logic [7:0]    rx_char_data,
    output logic [CW-1:0] tx_lane0_count,
    output logic [CW-1:0] tx_lane1_count,
    output logic [CW-1:0] rx_lane0_count,
    output logic [CW-1:0] rx_lane1_count
);
    beat_t tx_beat, rx_beat;

    assign tx_word_data   = tx_beat.data;
    assign tx_word_last   = tx_beat.last;
    assign tx_word_single = tx_beat.single;
    assign rx_beat        = '{data: rx_word_data, last: rx_word_last, single: rx_word_single};

    bwl_tx_path #(.DEPTH(DEPTH), .WAIT_LIMIT(WAIT_LIMIT), .LEVEL_LIMIT(LEVEL_LIMIT)) tx_i (
        .clk(clk), .rst(rst),
        .ch_valid(tx_char_valid), .ch_ready(tx_char_ready), .ch_data(tx_char_data),
        .wd_valid(tx_word_valid), .wd_ready(tx_word_ready), .wd_beat(tx_beat),
        .fl_valid(flush_valid), .fl_count(flush_count), .fl_even(flush_even),
        .fl_ack(flush_ack),
        .cnt0(tx_lane0_count), .cnt1(tx_lane1_count)
    );

    bwl_rx_path #(.DEPTH(DEPTH)) rx_i (
        .clk(clk), .rst(rst),
        .wd_valid(rx_word_valid), .wd_ready(rx_word_ready), .wd_beat(rx_beat),
        .ch_valid(rx_char_valid), .ch_ready(rx_char_ready), .ch_data(rx_char_data),
        .cnt0(rx_lane0_count), .cnt1(rx_lane1_count)
    );

endmodule

// File: rtl/bwl_fifo_chk.sv
module bwl_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_char_ready,
    input logic          tx_word_valid,
    input logic [15:0]   tx_word_data,
    input logic          tx_word_last,
    input logic          tx_word_single,
    input logic          flush_valid,
    input logic [CW:0]   flush_count,
    input logic          flush_ack,
    input logic          rx_word_ready,
    input logic          rx_word_last,
    input logic          rx_word_single,
    input logic          rx_char_valid,
    input logic [CW-1:0] tx_lane0_count,
    input logic [CW-1:0] tx_lane1_count,
    input logic [CW-1:0] rx_lane0_count,
    input logic [CW-1:0] rx_lane1_count
);
    p_tx_full_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_lane0_count == CW'(DEPTH) && tx_lane1_count == CW'(DEPTH)) |-> !tx_char_ready);

    p_pair_needs_both_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_word_valid && !tx_word_single) |-> (tx_lane0_count != '0 && tx_lane1_count != '0));

    p_lone_low_half_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_word_valid && tx_word_single) |-> (tx_word_last && tx_word_data[15:8] == 8'h00));

    p_flush_count_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_valid) |-> (flush_count == $past({1'b0, tx_lane0_count} + {1'b0, tx_lane1_count})));

    p_flush_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !flush_ack) |=> (flush_valid && $stable(flush_count)));

    p_flush_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_ack) |=> !flush_valid);

    p_rx_pair_room_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_word_ready && !(rx_word_last && rx_word_single)) |->
        (rx_lane0_count != CW'(DEPTH) && rx_lane1_count != CW'(DEPTH)));

    p_rx_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_lane0_count == '0 && rx_lane1_count == '0) |-> !rx_char_valid);

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((tx_lane0_count == $past(tx_lane0_count)) ||
                  (tx_lane0_count == $past(tx_lane0_count) + 1'b1) ||
                  (tx_lane0_count == $past(tx_lane0_count) - 1'b1)));

endmodule

bind bwl_fifo bwl_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst),
    .tx_char_ready(tx_char_ready), .tx_word_valid(tx_word_valid),
    .tx_word_data(tx_word_data), .tx_word_last(tx_word_last),
    .tx_word_single(tx_word_single), .flush_valid(flush_valid),
    .flush_count(flush_count), .flush_ack(flush_ack),
    .rx_word_ready(rx_word_ready), .rx_word_last(rx_word_last),
    .rx_word_single(rx_word_single), .rx_char_valid(rx_char_valid),
    .tx_lane0_count(tx_lane0_count), .tx_lane1_count(tx_lane1_count),
    .rx_lane0_count(rx_lane0_count), .rx_lane1_count(rx_lane1_count)
);

// File: tb/bwl_fifo_tb_top.sv
`timescale 1ns/1ps
module bwl_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    // receive vectors: {last, single, data}
    localparam logic [17:0] RX_VEC [6] = '{
        {1'b0, 1'b0, 16'h1211},
        {1'b0, 1'b0, 16'h2221},
        {1'b1, 1'b1, 16'hEE31},
        {1'b0, 1'b0, 16'h4241},
        {1'b1, 1'b0, 16'h5251},
        {1'b1, 1'b1, 16'h9961}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic tx_char_valid = 0, tx_word_ready = 0, flush_ack = 0;
    logic [7:0] tx_char_data = 0;
    logic rx_word_valid = 0, rx_word_last = 0, rx_word_single = 0, rx_char_ready = 0;
    logic [15:0] rx_word_data = 0;
    logic tx_char_ready, tx_word_valid, tx_word_last, tx_word_single;
    logic [15:0] tx_word_data;
    logic flush_valid, flush_even, rx_word_ready, rx_char_valid;
    logic [CW:0] flush_count;
    logic [7:0] rx_char_data;
    logic [CW-1:0] tx_lane0_count, tx_lane1_count, rx_lane0_count, rx_lane1_count;

    int total = 0, bad = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2.5 clk = ~clk;

    bwl_fifo #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_put(input logic [7:0] b);
        tx_char_valid = 1; tx_char_data = b;
        @(posedge clk); @(negedge clk);
        txq.push_back(b);
    endtask

    task automatic tx_drain();
        tx_word_ready = 1;
        while (txq.size() > 0) begin
            if (txq.size() >= 2) begin
                chk(tx_word_valid && !tx_word_single, "R3 pair valid", tx_word_single, 0);
                chk(tx_word_data == {txq[1], txq[0]}, "R3 pair data", tx_word_data, {txq[1], txq[0]});
                chk(tx_word_last == (txq.size() == 2), "R3 last", tx_word_last, txq.size() == 2);
                void'(txq.pop_front()); void'(txq.pop_front());
            end else begin
                chk(tx_word_valid && tx_word_single && tx_word_last, "R4 lone flags",
                    {tx_word_valid, tx_word_last, tx_word_single}, 3'b111);
                chk(tx_word_data == {8'h00, txq[0]}, "R4 lone data", tx_word_data, {8'h00, txq[0]});
                void'(txq.pop_front());
            end
            @(posedge clk); @(negedge clk);
        end
        tx_word_ready = 0;
        chk(!tx_word_valid, "R3 drained", tx_word_valid, 0);
    endtask

    task automatic fl_clear();
        repeat (2) @(negedge clk);
        if (flush_valid) begin
            flush_ack = 1;
            @(posedge clk); @(negedge clk);
            flush_ack = 0;
        end
        @(negedge clk);
    endtask

    task automatic rx_put(input logic [17:0] v);
        rx_word_valid = 1; rx_word_last = v[17]; rx_word_single = v[16]; rx_word_data = v[15:0];
        @(posedge clk); @(negedge clk);
        rxq.push_back(v[7:0]);
        if (!(v[17] && v[16])) rxq.push_back(v[15:8]);
        rx_word_valid = 0;
    endtask

    task automatic rx_drain();
        rx_char_ready = 1;
        while (rxq.size() > 0) begin
            chk(rx_char_valid, "R10 valid while data", rx_char_valid, 1);
            chk(rx_char_data == rxq[0], "R8 R9 order", rx_char_data, rxq[0]);
            void'(rxq.pop_front());
            @(posedge clk); @(negedge clk);
        end
        rx_char_ready = 0;
        chk(!rx_char_valid, "R10 empty", rx_char_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(tx_lane0_count == 0 && tx_lane1_count == 0 && rx_lane0_count == 0 && rx_lane1_count == 0,
            "R1 counts", tx_lane0_count, 0);
        chk(!tx_word_valid && !rx_char_valid && !flush_valid, "R1 valids",
            {tx_word_valid, rx_char_valid, flush_valid}, 0);
        chk(tx_char_ready && rx_word_ready, "R1 readies", {tx_char_ready, rx_word_ready}, 2'b11);

        // R2 R11 alternating lanes, odd length
        for (int i = 0; i < 5; i++) tx_put(8'hA0 + 8'(i));
        tx_char_valid = 0;
        chk(tx_lane0_count == 3 && tx_lane1_count == 2, "R2 R11 lane split",
            {tx_lane0_count, tx_lane1_count}, {5'd3, 5'd2});
        tx_drain();
        // R4 alignment after lone beat
        for (int i = 0; i < 4; i++) tx_put(8'hB0 + 8'(i));
        tx_char_valid = 0;
        tx_drain();
        fl_clear();

        // R2 fill both lanes
        for (int i = 0; i < 2 * DEPTH; i++) begin
            if (i == 2 * DEPTH - 1)
                chk(tx_char_ready, "R2 ready one slot left", tx_char_ready, 1);
            tx_put(8'h40 + 8'(i));
        end
        tx_char_valid = 0;
        chk(!tx_char_ready, "R2 ready when full", tx_char_ready, 0);
        chk(tx_lane0_count == DEPTH && tx_lane1_count == DEPTH, "R11 full counts",
            tx_lane0_count, DEPTH);
        tx_drain();
        fl_clear();

        // R5 timed flush
        tx_put(8'hC7);
        tx_char_valid = 0;
        repeat (22) @(posedge clk);
        @(negedge clk);
        chk(!flush_valid, "R5 not yet", flush_valid, 0);
        @(posedge clk); @(negedge clk);
        chk(flush_valid, "R5 raised", flush_valid, 1);
        chk(flush_count == 1 && !flush_even, "R6 count lone", flush_count, 1);
        repeat (3) @(negedge clk);
        chk(flush_valid && flush_count == 1, "R7 held", flush_valid, 1);
        flush_ack = 1;
        @(posedge clk); @(negedge clk);
        flush_ack = 0;
        chk(!flush_valid, "R7 cleared", flush_valid, 0);
        tx_drain();
        fl_clear();

        // R6 level flush
        for (int i = 0; i < 9; i++) begin
            if (i == 8) chk(!flush_valid, "R6 below level", flush_valid, 0);
            tx_put(8'h60 + 8'(i));
        end
        tx_char_valid = 0;
        @(posedge clk); @(negedge clk);
        chk(flush_valid && flush_count == 9, "R6 level count", flush_count, 9);
        chk(!flush_even, "R6 odd flag", flush_even, 0);
        fl_clear();
        tx_drain();
        fl_clear();

        // R6 even flag
        tx_put(8'h71); tx_put(8'h72);
        tx_char_valid = 0;
        repeat (30) @(negedge clk);
        chk(flush_valid && flush_count == 2, "R6 even count", flush_count, 2);
        chk(flush_even, "R6 even flag", flush_even, 1);
        fl_clear();
        tx_drain();

        // R8 R9 vector table
        for (int v = 0; v < 6; v++) rx_put(RX_VEC[v]);
        chk(rx_lane0_count == 5 && rx_lane1_count == 5, "R11 rx counts",
            {rx_lane0_count, rx_lane1_count}, {5'd5, 5'd5});
        rx_drain();

        // R10 read on empty has no effect
        rx_char_ready = 1;
        repeat (2) @(negedge clk);
        rx_char_ready = 0;
        chk(rx_lane0_count == 0 && rx_lane1_count == 0, "R10 no count change", rx_lane0_count, 0);
        rx_put({2'b00, 16'h7271});
        rx_drain();

        // R8 full receive lanes refuse a pair
        for (int i = 0; i < DEPTH; i++) rx_put({2'b00, 16'(16'h8000 + i * 2)});
        chk(!rx_word_ready, "R8 ready when full", rx_word_ready, 0);
        rx_drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule